// File: doc/BRIEF.md
# Serial Clock-Synthesizer Configuration Writer

This block sits on the host side of a three-wire configuration link to a serially programmed clock synthesizer. The link has a serial clock, a data line and a latch strobe. A single-cycle start pulse captures six parallel fields: a 7-bit reference divider word, a 9-bit VCO divider word, a 3-bit output divider select, a 2-bit function select, a one-bit output mode flag and a 2-bit load-capacitance code. The block packs these fields into one 24-bit frame and shifts the frame out most significant bit first. The receiver samples each bit on the rising edge of the serial clock.

The serial clock idles low. Data changes only on its falling edge, or when a frame is loaded. The strobe stays low for the whole shift. After the last bit, the block waits a fixed number of system clocks, raises the strobe for a fixed number of system clocks to commit the frame, and then signals completion. The half bit period, the wait and the strobe width are parameters counted in system clocks. Built-in checks confirm, at the stated system clock period, that data setup and hold are each at least 10 ns, that the serial clock stays at or below 50 MHz, that the post-shift wait is at least 10 ns and that the strobe width is at least 40 ns.

Top module: `synth_cfg_writer`

## Requirements
- R1: The frame, first bit on the wire to last, is capCode[1:0], dutyMode, funcSel[1:0], outSel[2:0], vcoDiv[8:0], refDiv[6:0]. As a 24-bit word, frame[23:22]=capCode, frame[21]=dutyMode, frame[20:19]=funcSel, frame[18:16]=outSel, frame[15:7]=vcoDiv and frame[6:0]=refDiv. Frame bit 23 goes out first.
- R2: The inputs refDiv=59, vcoDiv=276, outSel=1, funcSel=2, dutyMode=1 and capCode=0 produce the wire bytes 00110001, 10001010, 00111011, which is the word 24'h318A3B.
- R3: serClk is low when idle. While busy, serData changes only in the cycle in which serClk falls. The first bit of a frame is presented in the cycle after start.
- R4: Every high phase of serClk lasts exactly HALF_CYC system clocks. Every low phase before a rising edge, including the first one after start, lasts exactly HALF_CYC system clocks.
- R5: Each frame produces exactly 24 rising edges of serClk, and serStrobe is low at every one of them.
- R6: After the last falling edge of serClk, serStrobe stays low for exactly WAIT_CYC system clocks. It is then high for exactly STB_CYC system clocks.
- R7: busy rises in the cycle after an accepted start and falls in the cycle in which serStrobe falls. done is a one-cycle pulse in that same cycle.
- R8: A start that arrives while busy is high is ignored. It neither changes the frame in progress nor starts a second frame.
- R9: With SYS_PERIOD_NS=10, HALF_CYC=2, WAIT_CYC=2 and STB_CYC=5, each serClk phase lasts at least 10 ns, which covers setup, hold and a serial clock of at most 50 MHz. The wait is also at least 10 ns, and the strobe width is at least 40 ns.
- R10: During and after reset, serClk, serData, serStrobe, busy and done are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to send a frame |
| capCode | input | 2 | Load-capacitance code |
| dutyMode | input | 1 | Output drive/duty mode flag |
| funcSel | input | 2 | Function select for the second output |
| outSel | input | 3 | Output divider select |
| vcoDiv | input | 9 | VCO divider word |
| refDiv | input | 7 | Reference divider word |
| serClk | output | 1 | Serial clock to the synthesizer |
| serData | output | 1 | Serial data to the synthesizer |
| serStrobe | output | 1 | Latch strobe to the synthesizer |
| busy | output | 1 | A frame is being sent or committed |
| done | output | 1 | One-cycle pulse when the strobe falls |

## Verification
The assertions assume that the field inputs are stable in the cycle that start is high. Fields are captured in that cycle only, so later changes are irrelevant. The assertions also assume that reset is held for at least one clock edge. The bench drives all inputs on the falling system-clock edge, holds start for exactly one cycle, and issues starts only from idle, except in the scenario that deliberately pulses start while busy. The timing-minimum assertions are evaluated with the bench clock period equal to SYS_PERIOD_NS.

// File: rtl/synth_cfg_pkg.sv
`timescale 1ns/1ps
package synth_cfg_pkg;

  localparam int CAP_W    = 2;
  localparam int FUNC_W   = 2;
  localparam int OSEL_W   = 3;
  localparam int VCO_W    = 9;
  localparam int REF_W    = 7;
  localparam int FRAME_W  = CAP_W + 1 + FUNC_W + OSEL_W + VCO_W + REF_W;

  // Link timing minimums of the synthesizer, in ns
  localparam int MIN_SETUP_NS = 10;
  localparam int MIN_HOLD_NS  = 10;
  localparam int MIN_WAIT_NS  = 10;
  localparam int MIN_STB_NS   = 40;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_GAP,
    ST_STB
  } wrState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic rise;
    logic fall;
    logic shift;
    logic stbOn;
    logic stbOff;
  } dpCtl_t;

  function automatic logic [FRAME_W-1:0] packFrame(
    input logic [CAP_W-1:0]  cap,
    input logic              duty,
    input logic [FUNC_W-1:0] func,
    input logic [OSEL_W-1:0] osel,
    input logic [VCO_W-1:0]  vco,
    input logic [REF_W-1:0]  refw
  );
    return {cap, duty, func, osel, vco, refw};
  endfunction

endpackage

// File: rtl/synth_cfg_ctrl.sv
`timescale 1ns/1ps
module synth_cfg_ctrl
  import synth_cfg_pkg::*;
#(
  parameter int HALF_CYC = 2,
  parameter int WAIT_CYC = 2,
  parameter int STB_CYC  = 5
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   done
);

  localparam int MAX_A  = (HALF_CYC > WAIT_CYC) ? HALF_CYC : WAIT_CYC;
  localparam int MAX_T  = (MAX_A > STB_CYC) ? MAX_A : STB_CYC;
  localparam int TMR_W  = (MAX_T > 1) ? $clog2(MAX_T) : 1;
  localparam int BITS_W = $clog2(FRAME_W);

  localparam logic [TMR_W-1:0]  HALF_LD = TMR_W'(HALF_CYC - 1);
  localparam logic [TMR_W-1:0]  WAIT_LD = TMR_W'(WAIT_CYC - 1);
  localparam logic [TMR_W-1:0]  STB_LD  = TMR_W'(STB_CYC - 1);
  localparam logic [BITS_W-1:0] LAST_IX = BITS_W'(FRAME_W - 1);

  wrState_t          state, nextState;
  logic [TMR_W-1:0]  timer, nextTimer;
  logic [BITS_W-1:0] bitsLeft, nextBits;
  logic              nextDone;
  logic              timerZero;

  assign timerZero = (timer == '0);

  always_comb begin
    ctl       = '0;
    nextState = state;
    nextTimer = timer;
    nextBits  = bitsLeft;
    nextDone  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.load  = 1'b1;
          nextState = ST_LOW;
          nextTimer = HALF_LD;
          nextBits  = LAST_IX;
        end
      end
      ST_LOW: begin
        if (timerZero) begin
          ctl.rise  = 1'b1;
          nextState = ST_HIGH;
          nextTimer = HALF_LD;
        end else begin
          nextTimer = timer - 1'b1;
        end
      end
      ST_HIGH: begin
        if (timerZero) begin
          ctl.fall = 1'b1;
          if (bitsLeft == '0) begin
            nextState = ST_GAP;
            nextTimer = WAIT_LD;
          end else begin
            ctl.shift = 1'b1;
            nextBits  = bitsLeft - 1'b1;
            nextState = ST_LOW;
            nextTimer = HALF_LD;
          end
        end else begin
          nextTimer = timer - 1'b1;
        end
      end
      ST_GAP: begin
        if (timerZero) begin
          ctl.stbOn = 1'b1;
          nextState = ST_STB;
          nextTimer = STB_LD;
        end else begin
          nextTimer = timer - 1'b1;
        end
      end
      ST_STB: begin
        if (timerZero) begin
          ctl.stbOff = 1'b1;
          nextDone   = 1'b1;
          nextState  = ST_IDLE;
        end else begin
          nextTimer = timer - 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      timer    <= '0;
      bitsLeft <= '0;
      done     <= 1'b0;
    end else begin
      state    <= nextState;
      timer    <= nextTimer;
      bitsLeft <= nextBits;
      done     <= nextDone;
    end
  end

  assign busy = (state != ST_IDLE);

  // R7
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |-> !ctl.load);

endmodule

// File: rtl/synth_cfg_dp.sv
`timescale 1ns/1ps
module synth_cfg_dp
  import synth_cfg_pkg::*;
#(
  parameter int SYS_PERIOD_NS = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [FRAME_W-1:0] frameIn,
  output logic               serClk,
  output logic               serData,
  output logic               serStrobe
);

  localparam int CNT_W = 16;

  logic [FRAME_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      serClk    <= 1'b0;
      serStrobe <= 1'b0;
    end else begin
      if (ctl.load)       shiftReg <= frameIn;
      else if (ctl.shift) shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};

      if (ctl.load || ctl.fall) serClk <= 1'b0;
      else if (ctl.rise)        serClk <= 1'b1;

      if (ctl.stbOn)       serStrobe <= 1'b1;
      else if (ctl.stbOff) serStrobe <= 1'b0;
    end
  end

  assign serData = shiftReg[FRAME_W-1];

  // Phase counters used only by the timing checks below
  logic [CNT_W-1:0] loCnt, hiCnt, stbCnt;
  logic             loadQ;

  function automatic logic [CNT_W-1:0] satInc(input logic [CNT_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loCnt  <= '0;
      hiCnt  <= '0;
      stbCnt <= '0;
      loadQ  <= 1'b0;
    end else begin
      loadQ  <= ctl.load;
      loCnt  <= ctl.load ? '0 : (serClk ? '0 : satInc(loCnt));
      hiCnt  <= serClk ? satInc(hiCnt) : '0;
      stbCnt <= serStrobe ? satInc(stbCnt) : '0;
    end
  end

  // R3
  data_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (serData != $past(serData)) |-> ($fell(serClk) || loadQ));

  // R5
  strobe_low_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serClk) |-> !serStrobe);

  // R9 setup: low phase since the last data change; with the hold check this bounds the rate to 50 MHz
  setup_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serClk) |-> (int'(loCnt) * SYS_PERIOD_NS >= MIN_SETUP_NS));

  // R9 hold: high phase before data may change
  hold_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(serClk) |-> (int'(hiCnt) * SYS_PERIOD_NS >= MIN_HOLD_NS));

  // R9 wait after the last bit
  wait_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serStrobe) |-> (int'(loCnt) * SYS_PERIOD_NS >= MIN_WAIT_NS));

  // R9 strobe width
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(serStrobe) |-> (int'(stbCnt) * SYS_PERIOD_NS >= MIN_STB_NS));

endmodule

// File: rtl/synth_cfg_writer.sv
`timescale 1ns/1ps
module synth_cfg_writer
  import synth_cfg_pkg::*;
#(
  parameter int SYS_PERIOD_NS = 10,
  parameter int HALF_CYC      = 2,
  parameter int WAIT_CYC      = 2,
  parameter int STB_CYC       = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] capCode,
  input  logic       dutyMode,
  input  logic [1:0] funcSel,
  input  logic [2:0] outSel,
  input  logic [8:0] vcoDiv,
  input  logic [6:0] refDiv,
  output logic       serClk,
  output logic       serData,
  output logic       serStrobe,
  output logic       busy,
  output logic       done
);

  dpCtl_t             ctl;
  logic [FRAME_W-1:0] frameWord;

  // R1
  assign frameWord = packFrame(capCode, dutyMode, funcSel, outSel, vcoDiv, refDiv);

  synth_cfg_ctrl #(
    .HALF_CYC (HALF_CYC),
    .WAIT_CYC (WAIT_CYC),
    .STB_CYC  (STB_CYC)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctl   (ctl),
    .busy  (busy),
    .done  (done)
  );

  synth_cfg_dp #(
    .SYS_PERIOD_NS (SYS_PERIOD_NS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .frameIn   (frameWord),
    .serClk    (serClk),
    .serData   (serData),
    .serStrobe (serStrobe)
  );

endmodule

// File: tb/synth_cfg_writer_bench.sv
`timescale 1ns/1ps
module synth_cfg_writer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_CYC   = 2;
  localparam int WAIT_CYC   = 2;
  localparam int STB_CYC    = 5;
  localparam int WDOG_LIMIT = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [1:0] capCode = '0;
  logic       dutyMode = 1'b0;
  logic [1:0] funcSel = '0;
  logic [2:0] outSel = '0;
  logic [8:0] vcoDiv = '0;
  logic [6:0] refDiv = '0;
  logic       serClk, serData, serStrobe, busy, done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_cfg_writer #(
    .SYS_PERIOD_NS (CLK_PERIOD),
    .HALF_CYC      (HALF_CYC),
    .WAIT_CYC      (WAIT_CYC),
    .STB_CYC       (STB_CYC)
  ) u_synth_cfg_writer (
    .clk, .rstN, .start, .capCode, .dutyMode, .funcSel, .outSel,
    .vcoDiv, .refDiv, .serClk, .serData, .serStrobe, .busy, .done
  );

  // Monitor: samples on the falling system-clock edge
  logic [23:0] rxFrame = '0;
  int rxBits = 0, doneCnt = 0, frameCnt = 0;
  int hiBad = 0, loBad = 0, dataBad = 0, gapBad = 0, stbBad = 0, shiftStbBad = 0, doneBad = 0;
  int hiRun = 0, loRun = 0, stbRun = 0;
  int minHi = 1000, minLo = 1000, minGap = 1000, minStb = 1000;
  logic prevClk = 0, prevStb = 0, prevBusy = 0, prevData = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (busy && !prevBusy) begin
        frameCnt++;
        rxBits = 0;
        rxFrame = '0;
        loRun = 1;
      end else if (serClk && !prevClk) begin
        rxFrame = {rxFrame[22:0], serData};
        rxBits++;
        if (serStrobe) shiftStbBad++;
        if (loRun != HALF_CYC) loBad++;
        if (loRun < minLo) minLo = loRun;
        hiRun = 1;
      end else if (!serClk && prevClk) begin
        if (hiRun != HALF_CYC) hiBad++;
        if (hiRun < minHi) minHi = hiRun;
        loRun = 1;
      end else if (serClk) begin
        hiRun++;
      end else if (!serStrobe) begin
        loRun++;
      end
      if (busy && prevBusy && serData != prevData && !(prevClk && !serClk)) dataBad++;
      if (serStrobe && !prevStb) begin
        if (loRun != WAIT_CYC) gapBad++;
        if (loRun < minGap) minGap = loRun;
        stbRun = 1;
      end else if (serStrobe) begin
        stbRun++;
      end else if (prevStb) begin
        if (stbRun != STB_CYC) stbBad++;
        if (stbRun < minStb) minStb = stbRun;
      end
      if (done) begin
        doneCnt++;
        if (serStrobe || busy || !prevStb) doneBad++;
      end
    end
    prevClk = serClk;
    prevStb = serStrobe;
    prevBusy = busy;
    prevData = serData;
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic setFields(input logic [1:0] c, input logic d, input logic [1:0] f,
                           input logic [2:0] s, input logic [8:0] v, input logic [6:0] r);
    capCode = c; dutyMode = d; funcSel = f; outSel = s; vcoDiv = v; refDiv = r;
  endtask

  task automatic pulseStart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(input int startCnt);
    int n = 0;
    while (doneCnt == startCnt && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Send one frame and check wire content and timing
  task automatic sendFrame(input string tag, input logic [1:0] c, input logic d, input logic [1:0] f,
                           input logic [2:0] s, input logic [8:0] v, input logic [6:0] r,
                           input logic [23:0] exp);
    int d0 = doneCnt, hb = hiBad, lb = loBad, db = dataBad, gb = gapBad, sb = stbBad;
    int ssb = shiftStbBad, dnb = doneBad;
    setFields(c, d, f, s, v, r);
    pulseStart();
    check("R7", {tag, " busy after start"}, busy, 1);
    waitDone(d0);
    check("R1", {tag, " frame"}, rxFrame, exp);
    check("R5", {tag, " bit count"}, rxBits, 24);
    check("R5", {tag, " strobe low at rises"}, shiftStbBad - ssb, 0);
    check("R3", {tag, " data changes off falling edge"}, dataBad - db, 0);
    check("R4", {tag, " bad phases"}, (hiBad - hb) + (loBad - lb), 0);
    check("R6", {tag, " wait/strobe width"}, (gapBad - gb) + (stbBad - sb), 0);
    check("R7", {tag, " done alignment"}, doneBad - dnb, 0);
    check("R7", {tag, " one done"}, doneCnt - d0, 1);
    @(negedge clk);
    check("R3", {tag, " serClk idles low"}, serClk, 0);
  endtask

  task automatic testReset();
    check("R10", "serClk", serClk, 0);
    check("R10", "serData", serData, 0);
    check("R10", "serStrobe", serStrobe, 0);
    check("R10", "busy", busy, 0);
    check("R10", "done", done, 0);
  endtask

  task automatic testExample();
    sendFrame("R2", 2'd0, 1'b1, 2'd2, 3'd1, 9'd276, 7'd59, 24'h318A3B);
  endtask

  task automatic testPatterns();
    sendFrame("ones", 2'h3, 1'b1, 2'h3, 3'h7, 9'h1FF, 7'h7F, 24'hFFFFFF);
    sendFrame("zeros", 2'h0, 1'b0, 2'h0, 3'h0, 9'h000, 7'h00, 24'h000000);
    sendFrame("alt", 2'h2, 1'b1, 2'h1, 3'h2, 9'h0AA, 7'h55,
              {2'h2, 1'b1, 2'h1, 3'h2, 9'h0AA, 7'h55});
    sendFrame("fields", 2'h1, 1'b0, 2'h3, 3'h5, 9'h123, 7'h01,
              {2'h1, 1'b0, 2'h3, 3'h5, 9'h123, 7'h01});
  endtask

  // R8: start while busy is ignored
  task automatic testIgnoredStart();
    int d0 = doneCnt, f0 = frameCnt;
    setFields(2'h1, 1'b1, 2'h2, 3'h3, 9'h155, 7'h2A);
    pulseStart();
    repeat (30) @(negedge clk);
    setFields(2'h2, 1'b0, 2'h1, 3'h4, 9'h0F0, 7'h15);
    pulseStart();
    waitDone(d0);
    check("R8", "frame unchanged by late start", rxFrame, {2'h1, 1'b1, 2'h2, 3'h3, 9'h155, 7'h2A});
    repeat (40) @(negedge clk);
    check("R8", "no second frame", frameCnt - f0, 1);
    check("R8", "idle after frame", busy, 0);
  endtask

  task automatic testMinimums();
    check("R9", "setup min", (minLo * CLK_PERIOD >= 10), 1);
    check("R9", "hold min", (minHi * CLK_PERIOD >= 10), 1);
    check("R9", "wait min", (minGap * CLK_PERIOD >= 10), 1);
    check("R9", "strobe min", (minStb * CLK_PERIOD >= 40), 1);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < WDOG_LIMIT) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog: actual %0d expected < %0d cycles", cyc, WDOG_LIMIT);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testExample();
    testPatterns();
    testIgnoredStart();
    testMinimums();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule